// File: doc/BRIEF.md
# Per-Channel Gain and Offset Corrector

This block corrects converter codes with a gain and offset that are stored separately for each channel. It serves two directions, each with its own channels. The input direction takes raw 16-bit readings from an analog-to-digital path. The output direction takes requested 14-bit codes on their way to a digital-to-analog path. A table holds one gain word and one offset word for every channel in each direction. A write port loads that table at startup and again after a calibration run.

Every accepted sample is scaled by its channel's gain, a 32-bit unsigned value with 16 fraction bits. The product is rounded to the nearest code. The channel's signed offset is then added, and the result is clamped to the legal code range of its direction. The result leaves the block two cycles after it was accepted, tagged with its direction and channel.

A bypass request forces unity gain and zero offset on every channel, and this holds until the next reset. A parameter that falls outside its expected window is still stored, but it raises a flag for its channel.

Top module: `gcorr_unit`

## Requirements
- R1: The gain is unsigned with 16 fraction bits, so 0x00010000 is 1.0. The scaled value is (code × gain + 0x8000) >> 16, which rounds half up.
- R2: After scaling, the channel's offset is added. The offset is a 16-bit two's-complement value, and one LSB is one code.
- R3: The result is clamped below at 0. It is clamped above at 0xFFFF for the input direction (dir = 0) and at 0x3FFF for the output direction (dir = 1). It never wraps.
- R4: Each of the 16 channels in each direction has its own gain and offset. A write with wr_sel = 0 stores wr_data as the gain. A write with wr_sel = 1 stores wr_data[15:0] as the offset. A write changes no other entry.
- R5: range_flags bit (dir × 16 + chan) is 1 while that entry's gain lies outside 0x0000F000..0x00011111 or its offset lies outside −15..+15. An out-of-window value is still stored and still used.
- R6: A single-cycle pulse on bypass_req makes every channel use gain 1.0 and offset 0 from that cycle on. This holds after the request drops, until reset.
- R7: A sample taken when in_valid and in_ready are both high appears on out_valid/out_code exactly two clock edges later, with the same out_dir and out_chan. in_ready is high whenever reset is low.
- R8: Synchronous active-high reset sets every entry to gain 1.0 and offset 0, clears the bypass, clears range_flags and deasserts out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_req | input | 1 | Request neutral correction until reset |
| wr_en | input | 1 | Table write strobe |
| wr_dir | input | 1 | Write direction: 0 input side, 1 output side |
| wr_chan | input | 4 | Channel to write |
| wr_sel | input | 1 | 0 writes the gain, 1 writes the offset |
| wr_data | input | 32 | Gain word, or offset in bits 15:0 |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_dir | input | 1 | Sample direction |
| in_chan | input | 4 | Sample channel |
| in_code | input | 16 | Raw code |
| out_valid | output | 1 | Corrected result valid |
| out_dir | output | 1 | Direction tag of the result |
| out_chan | output | 4 | Channel tag of the result |
| out_code | output | 16 | Corrected, clamped code |
| range_flags | output | 32 | Out-of-window flag for each table entry |

## Verification
A wrong table entry shows on the very next sample for that channel, two cycles after the sample is taken. A corrupted flag shows on range_flags one cycle after the write that caused it. A lost bypass state shows as a non-neutral result on the first sample sent to any channel whose parameters are not neutral. A wrong tag or pipeline slip shows as a result on the wrong cycle or with the wrong channel number. The test vectors therefore pick channels whose parameters differ, so that a mixed-up entry cannot give the correct code by chance.

// File: rtl/gcorr_pkg.sv
package gcorr_pkg;

    parameter int NCH     = 16;
    parameter int CODE_W  = 16;
    parameter int GAIN_W  = 32;
    parameter int OFS_W   = 16;
    parameter int FRAC    = 16;
    parameter int OFS_LIM = 15;

    localparam int CH_W   = $clog2(NCH);
    localparam int ENT    = 2 * NCH;
    localparam int ENT_W  = CH_W + 1;
    localparam int PROD_W = GAIN_W + CODE_W;
    localparam int SUM_W  = PROD_W - FRAC + 2;

    localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << FRAC;
    localparam logic [GAIN_W-1:0] GAIN_MIN = 32'h0000_F000;
    localparam logic [GAIN_W-1:0] GAIN_MAX = 32'h0001_1111;
    localparam logic [CODE_W-1:0] FS_IN    = 16'hFFFF;
    localparam logic [CODE_W-1:0] FS_OUT   = 16'h3FFF;
    localparam logic [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (FRAC - 1);

    typedef enum logic { DIR_IN = 1'b0, DIR_OUT = 1'b1 } dir_e;

    typedef struct packed {
        logic [GAIN_W-1:0]       gain;
        logic signed [OFS_W-1:0] ofs;
    } corr_t;

    typedef struct packed {
        logic              valid;
        dir_e              dir;
        logic [CH_W-1:0]   chan;
        logic [CODE_W-1:0] raw;
        corr_t             corr;
    } stage_t;

    localparam corr_t CORR_NEUTRAL = '{gain: GAIN_ONE, ofs: '0};

    function automatic logic gain_ok(input logic [GAIN_W-1:0] g);
        return (g >= GAIN_MIN) && (g <= GAIN_MAX);
    endfunction

    function automatic logic ofs_ok(input logic signed [OFS_W-1:0] o);
        return (o >= -OFS_W'(OFS_LIM)) && (o <= OFS_W'(OFS_LIM));
    endfunction

    function automatic logic [CODE_W-1:0] full_scale(input dir_e d);
        return (d == DIR_OUT) ? FS_OUT : FS_IN;
    endfunction

endpackage

// File: rtl/gcorr_table.sv
module gcorr_table
    import gcorr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ENT_W-1:0]   wr_idx,
    input  logic               wr_sel,
    input  logic [GAIN_W-1:0]  wr_data,
    input  logic [ENT_W-1:0]   rd_idx,
    output corr_t              rd_corr,
    output logic [ENT-1:0]     flags
);

    corr_t tbl [ENT];

    for (genvar e = 0; e < ENT; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[e] <= CORR_NEUTRAL;
            end else if (wr_en && (wr_idx == ENT_W'(e))) begin
                if (wr_sel) tbl[e].ofs  <= wr_data[OFS_W-1:0];
                else        tbl[e].gain <= wr_data;
            end
        end
        assign flags[e] = !gain_ok(tbl[e].gain) || !ofs_ok(tbl[e].ofs);
    end

    assign rd_corr = tbl[rd_idx];

    // R5
    gain_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && !gain_ok(wr_data)) |=> flags[$past(wr_idx)]);

    // R5
    ofs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && !ofs_ok(wr_data[OFS_W-1:0])) |=> flags[$past(wr_idx)]);

endmodule

// File: rtl/gcorr_pipe.sv
module gcorr_pipe
    import gcorr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  dir_e               in_dir,
    input  logic [CH_W-1:0]    in_chan,
    input  logic [CODE_W-1:0]  in_code,
    input  corr_t              corr,
    input  logic               neutral,
    output logic               out_valid,
    output dir_e               out_dir,
    output logic [CH_W-1:0]    out_chan,
    output logic [CODE_W-1:0]  out_code
);

    stage_t s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= take;
            s1.dir   <= in_dir;
            s1.chan  <= in_chan;
            s1.raw   <= in_code;
            s1.corr  <= neutral ? CORR_NEUTRAL : corr;
        end
    end

    logic [PROD_W-1:0]        rounded;
    logic [PROD_W-FRAC-1:0]   scaled;
    logic [FRAC-1:0]          unused_frac;
    logic signed [SUM_W-1:0]  sum;
    logic [CODE_W-1:0]        fs;
    logic [CODE_W-1:0]        clamped;

    always_comb begin
        rounded     = PROD_W'(s1.raw) * PROD_W'(s1.corr.gain) + HALF_LSB;
        scaled      = rounded[PROD_W-1:FRAC];
        unused_frac = rounded[FRAC-1:0];
        sum         = $signed({2'b00, scaled}) + SUM_W'(s1.corr.ofs);
        fs          = full_scale(s1.dir);
        if (sum < 0)                          clamped = '0;
        else if (sum > $signed(SUM_W'(fs)))   clamped = fs;
        else                                  clamped = sum[CODE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_dir   <= DIR_IN;
            out_chan  <= '0;
            out_code  <= '0;
        end else begin
            out_valid <= s1.valid;
            out_dir   <= s1.dir;
            out_chan  <= s1.chan;
            out_code  <= clamped;
        end
    end

    // R7
    tag_follow_chk: assert property (@(posedge clk) disable iff (rst)
        s1.valid |=> (out_valid && out_chan == $past(s1.chan) && out_dir == $past(s1.dir)));

    // R3
    out_span_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dir == DIR_OUT) |-> (out_code <= FS_OUT));

    // R6
    neutral_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && s1.corr == CORR_NEUTRAL && s1.dir == DIR_IN) |=> (out_code == $past(s1.raw)));

endmodule

// File: rtl/gcorr_unit.sv
module gcorr_unit
    import gcorr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bypass_req,
    input  logic               wr_en,
    input  logic               wr_dir,
    input  logic [CH_W-1:0]    wr_chan,
    input  logic               wr_sel,
    input  logic [GAIN_W-1:0]  wr_data,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_dir,
    input  logic [CH_W-1:0]    in_chan,
    input  logic [CODE_W-1:0]  in_code,
    output logic               out_valid,
    output logic               out_dir,
    output logic [CH_W-1:0]    out_chan,
    output logic [CODE_W-1:0]  out_code,
    output logic [ENT-1:0]     range_flags
);

    logic  byp_q;
    corr_t rd_corr;
    dir_e  res_dir;

    always_ff @(posedge clk) begin
        if (rst)             byp_q <= 1'b0;
        else if (bypass_req) byp_q <= 1'b1;
    end

    assign in_ready = !rst;

    gcorr_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  ({wr_dir, wr_chan}),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_idx  ({in_dir, in_chan}),
        .rd_corr (rd_corr),
        .flags   (range_flags)
    );

    gcorr_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .take      (in_valid && in_ready),
        .in_dir    (dir_e'(in_dir)),
        .in_chan   (in_chan),
        .in_code   (in_code),
        .corr      (rd_corr),
        .neutral   (byp_q || bypass_req),
        .out_valid (out_valid),
        .out_dir   (res_dir),
        .out_chan  (out_chan),
        .out_code  (out_code)
    );

    assign out_dir = res_dir;

    // R6
    bypass_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        byp_q |=> byp_q);

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && range_flags == '0));

endmodule

// File: tb/sim_gcorr_unit.sv
module sim_gcorr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        bypass_req;
    logic        wr_en;
    logic        wr_dir;
    logic [3:0]  wr_chan;
    logic        wr_sel;
    logic [31:0] wr_data;
    logic        in_valid;
    logic        in_ready;
    logic        in_dir;
    logic [3:0]  in_chan;
    logic [15:0] in_code;
    logic        out_valid;
    logic        out_dir;
    logic [3:0]  out_chan;
    logic [15:0] out_code;
    logic [31:0] range_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    gcorr_unit u0 (.*);

    // {dir, chan, code, expected}
    localparam int NV = 14;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 4'd3,  16'h1234, 16'h1234},  // R1 unity gain
        {1'b0, 4'd5,  16'h1000, 16'h1105},  // R1 R2 gain 1.0625, +5
        {1'b0, 4'd5,  16'hFFF0, 16'hFFFF},  // R3 input top clamp
        {1'b0, 4'd7,  16'h0002, 16'h0000},  // R3 bottom clamp
        {1'b0, 4'd7,  16'h0100, 16'h00ED},  // R2 negative offset
        {1'b0, 4'd9,  16'h0003, 16'h0002},  // R1 half rounds up
        {1'b0, 4'd9,  16'h0101, 16'h0081},  // R1 R5 out-of-window gain used
        {1'b1, 4'd2,  16'h3FF0, 16'h3FFF},  // R3 output top clamp
        {1'b1, 4'd2,  16'h0200, 16'h021F},  // R2 offset +15
        {1'b1, 4'd15, 16'h000A, 16'h0000},  // R3 offset -15 clamp
        {1'b1, 4'd15, 16'h3FFF, 16'h3FF0},  // R2
        {1'b1, 4'd4,  16'h0100, 16'h0121},  // R5 out-of-window offset used
        {1'b1, 4'd5,  16'h1000, 16'h1000},  // R4 other direction untouched
        {1'b0, 4'd4,  16'h0777, 16'h0777}   // R4 other direction untouched
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic d, input logic [3:0] c, input logic s, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_dir = d; wr_chan = c; wr_sel = s; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input string req, input logic d, input logic [3:0] c,
                        input logic [15:0] code, input logic [15:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_dir = d; in_chan = c; in_code = code;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R7 early"}, {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check({req, " R7 valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " R7 tag"}, {27'd0, out_dir, out_chan}, {27'd0, d, c});
        check(req, {16'd0, out_code}, {16'd0, exp});
    endtask

    initial begin
        rst = 1'b1; bypass_req = 1'b0; wr_en = 1'b0; wr_dir = 1'b0; wr_chan = '0;
        wr_sel = 1'b0; wr_data = '0; in_valid = 1'b0; in_dir = 1'b0; in_chan = '0; in_code = '0;
        repeat (3) @(negedge clk);
        check("R8 out_valid", {31'd0, out_valid}, 32'd0);
        check("R8 flags", range_flags, 32'd0);
        rst = 1'b0;

        wr(1'b0, 4'd5,  1'b0, 32'h0001_1000); wr(1'b0, 4'd5,  1'b1, 32'h0000_0005);
        wr(1'b0, 4'd7,  1'b0, 32'h0000_F000); wr(1'b0, 4'd7,  1'b1, 32'h0000_FFFD);
        wr(1'b0, 4'd9,  1'b0, 32'h0000_8000);
        wr(1'b1, 4'd2,  1'b0, 32'h0001_0800); wr(1'b1, 4'd2,  1'b1, 32'h0000_000F);
        wr(1'b1, 4'd15, 1'b1, 32'h0000_FFF1);
        wr(1'b1, 4'd4,  1'b0, 32'h0001_1111); wr(1'b1, 4'd4,  1'b1, 32'h0000_0010);
        @(negedge clk);
        check("R5 flags set", range_flags, 32'h0010_0200);

        for (int i = 0; i < NV; i++)
            send("R1/R2/R3/R4/R5 vector", VEC[i][36], VEC[i][35:32], VEC[i][31:16], VEC[i][15:0]);

        wr(1'b1, 4'd4, 1'b1, 32'h0000_000F);
        @(negedge clk);
        check("R5 flag clears", range_flags, 32'h0000_0200);

        @(negedge clk); bypass_req = 1'b1;
        @(negedge clk); bypass_req = 1'b0;
        repeat (2) @(negedge clk);
        send("R6 bypass input", 1'b0, 4'd5, 16'h1000, 16'h1000);
        send("R6 bypass output", 1'b1, 4'd15, 16'h000A, 16'h000A);
        send("R6 bypass round", 1'b0, 4'd9, 16'h0003, 16'h0003);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R8 flags after reset", range_flags, 32'd0);
        send("R8 table neutral", 1'b0, 4'd7, 16'h0100, 16'h0100);
        wr(1'b0, 4'd5, 1'b0, 32'h0001_1000); wr(1'b0, 4'd5, 1'b1, 32'h0000_0005);
        send("R8 bypass cleared", 1'b0, 4'd5, 16'h1000, 16'h1105);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule